// File: doc/BRIEF.md
# Floating-Point Register Transfer Address Sequencer

This block turns one decoded floating-point register load or store into a stream of 32-bit word requests on a simple valid/ready memory port. A transfer is either a single register (base plus or minus a scaled immediate), a multiple transfer that walks upward from the base, or a multiple transfer that first steps the base down and then walks upward (the stack push form). Popping from a stack is the upward multiple form with write-back.

For every word the block presents the byte address, the register-file index it belongs to and, for double-precision registers, which 32-bit half travels in that word. Double-precision halves are ordered by an endianness input captured at command acceptance. When the last word has been accepted, a one-cycle completion pulse carries the new base value and a flag saying whether it should be written back. Commands are taken only while the block is idle.

Top module: `fpx_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `req_valid` and `done` are low; reset leaves `busy` low.
- R2: The first register index is {vd, dbit} (vd in bits 4:1, dbit in bit 0) for single precision and {dbit, vd} (dbit in bit 4) for double precision; each following register uses the next index, wrapping modulo 32.
- R3: A double-precision register occupies two words at consecutive addresses; with `big_endian` high, the word at the lower address carries the upper half (`req_hi`=1), otherwise the lower half (`req_hi`=0). Single-precision words always show `req_hi`=0.
- R4: A multiple transfer issues `cmd_imm` words in single precision and 2×(`cmd_imm`>>1) words in double precision; a single-register transfer issues 1 or 2 words.
- R5: A multiple transfer with `cmd_up`=0 starts at base − 4×imm and reports that same value as the new base.
- R6: A multiple transfer with `cmd_up`=1 starts at the base and reports base + 4×imm as the new base.
- R7: A single-register transfer addresses base + 4×imm when `cmd_up`=1 and base − 4×imm otherwise, with the base first rounded up to a multiple of 4 when `cmd_base_pc` is set; it never requests write-back (`wb_en`=0).
- R8: Each word after the first is addressed 4 bytes above the previous one.
- R9: While `req_valid` is high and `mem_ready` is low, the address, index and half select are held unchanged.
- R10: `done` pulses for one cycle, in the cycle after the last word is accepted (or after acceptance for a zero-word transfer), together with `wb_value`; `wb_en` equals `cmd_wback` for multiple transfers.
- R11: `cmd_valid` is ignored while `busy` is high.
- R12: `req_write` is high for stores (`cmd_load`=0) and low for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when idle |
| cmd_load | input | 1 | 1 = load from memory, 0 = store |
| cmd_multi | input | 1 | 1 = multiple transfer, 0 = single register |
| cmd_up | input | 1 | Offset direction / upward walk select |
| cmd_wback | input | 1 | Write the new base back (multiple only) |
| cmd_double | input | 1 | 1 = double precision registers |
| cmd_base_pc | input | 1 | Base is the program counter (round up to 4) |
| cmd_base | input | ADDR_W | Base register value |
| cmd_imm | input | IMM_W | Word count / scaled offset |
| cmd_vd | input | VD_W | Four-bit register field |
| cmd_dbit | input | 1 | Extra register bit |
| big_endian | input | 1 | Half ordering for double registers |
| busy | output | 1 | A command is in progress |
| req_valid | output | 1 | Word request present |
| req_write | output | 1 | Request is a store |
| req_addr | output | ADDR_W | Word byte address |
| req_reg | output | VD_W+1 | Register-file index |
| req_hi | output | 1 | Word is the upper half of a double |
| mem_ready | input | 1 | Memory accepts the request |
| done | output | 1 | Transfer complete pulse |
| wb_en | output | 1 | Write `wb_value` to the base register |
| wb_value | output | ADDR_W | New base value |

## Verification
Each command is expanded in the bench into its expected word list and compared word for word as the memory port accepts them, with `mem_ready` both held high and throttled in a repeating pattern so stalls land on first, middle and last words. Single-register transfers in both directions, with and without program-counter rounding, separate the add and subtract paths from the multiple forms; upward and downward multiple transfers separate start-address and new-base computation. Double-precision runs in both endian settings with even and odd immediates distinguish half ordering, the halved word count and index stepping per pair, while a run starting at index 29 checks wrap. A zero-length transfer, a run without write-back and a command offered while busy cover the completion and ignore rules.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fpx_state_e;
endpackage

// File: rtl/fpx_plan.sv
// Combinational decode of a transfer command into its walk parameters.
module fpx_plan #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  parameter int VD_W   = 4,
  localparam int REG_W = VD_W + 1
) (
  input  logic              multi,
  input  logic              up,
  input  logic              dbl,
  input  logic              base_pc,
  input  logic              wback,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [VD_W-1:0]   vd,
  input  logic              dbit,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_req,
  output logic [IMM_W-1:0]  words,
  output logic [REG_W-1:0]  first_reg
);
  localparam int PAD_W = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base_adj;
  logic [ADDR_W-1:0] below;
  logic [ADDR_W-1:0] above;

  assign offset   = {{PAD_W{1'b0}}, imm, 2'b00};
  assign base_adj = (base_pc && !multi) ? ((base + ADDR_W'(3)) & ~ADDR_W'(3)) : base;
  assign below    = base_adj - offset;
  assign above    = base_adj + offset;

  always_comb begin
    if (multi) begin
      start_addr = up ? base_adj : below;
      wb_val     = up ? above : below;
      wb_req     = wback;
      words      = dbl ? {imm[IMM_W-1:1], 1'b0} : imm;
    end else begin
      start_addr = up ? above : below;
      wb_val     = base_adj;
      wb_req     = 1'b0;
      words      = dbl ? IMM_W'(2) : IMM_W'(1);
    end
    first_reg = dbl ? {dbit, vd} : {vd, dbit};
  end
endmodule

// File: rtl/fpx_step.sv
// Word-by-word walker with registered request outputs.
module fpx_step
  import fpx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IMM_W-1:0]  words,
  input  logic [REG_W-1:0]  first_reg,
  input  logic              dbl,
  input  logic              be,
  input  logic              load,
  input  logic              wb_req,
  input  logic [ADDR_W-1:0] wb_val,
  input  logic              mem_ready,
  output logic              busy,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic              req_hi,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  fpx_state_e        state_q;
  logic [IMM_W-1:0]  left_q;
  logic              par_q;
  logic              dbl_q;
  logic              be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_reg   <= '0;
      left_q    <= '0;
      par_q     <= 1'b0;
      dbl_q     <= 1'b0;
      be_q      <= 1'b0;
      wb_en     <= 1'b0;
      wb_value  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            req_addr  <= start_addr;
            req_reg   <= first_reg;
            req_write <= ~load;
            left_q    <= words;
            par_q     <= 1'b0;
            dbl_q     <= dbl;
            be_q      <= be;
            wb_en     <= wb_req;
            wb_value  <= wb_val;
            if (words == '0) begin
              state_q <= ST_FIN;
            end else begin
              state_q   <= ST_RUN;
              req_valid <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (mem_ready) begin
            if (left_q == IMM_W'(1)) begin
              req_valid <= 1'b0;
              state_q   <= ST_FIN;
            end else begin
              req_addr <= req_addr + ADDR_W'(4);
              left_q   <= left_q - IMM_W'(1);
              par_q    <= dbl_q & ~par_q;
              if (!dbl_q || par_q) req_reg <= req_reg + REG_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_FIN);
  assign req_hi = dbl_q & (be_q ^ par_q);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req_valid && !done));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_hi)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mem_ready) |=> (!req_valid || req_addr == $past(req_addr) + ADDR_W'(4)));

  p_reg_step_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mem_ready && !dbl_q) |=>
      (!req_valid || req_reg == $past(req_reg) + REG_W'(1)));

  p_half_swap_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mem_ready && dbl_q) |=> (!req_valid || req_hi != $past(req_hi)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  parameter int VD_W   = 4,
  localparam int REG_W = VD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_load,
  input  logic              cmd_multi,
  input  logic              cmd_up,
  input  logic              cmd_wback,
  input  logic              cmd_double,
  input  logic              cmd_base_pc,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [VD_W-1:0]   cmd_vd,
  input  logic              cmd_dbit,
  input  logic              big_endian,
  output logic              busy,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic              req_hi,
  input  logic              mem_ready,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  logic [ADDR_W-1:0] p_start;
  logic [ADDR_W-1:0] p_wb;
  logic              p_wbreq;
  logic [IMM_W-1:0]  p_words;
  logic [REG_W-1:0]  p_first;
  logic              accept;

  assign accept = cmd_valid & ~busy;

  fpx_plan #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .VD_W(VD_W)) u_plan (
    .multi(cmd_multi), .up(cmd_up), .dbl(cmd_double), .base_pc(cmd_base_pc),
    .wback(cmd_wback), .base(cmd_base), .imm(cmd_imm), .vd(cmd_vd),
    .dbit(cmd_dbit), .start_addr(p_start), .wb_val(p_wb), .wb_req(p_wbreq),
    .words(p_words), .first_reg(p_first)
  );

  fpx_step #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_step (
    .clk(clk), .rst(rst), .start(accept), .start_addr(p_start),
    .words(p_words), .first_reg(p_first), .dbl(cmd_double), .be(big_endian),
    .load(cmd_load), .wb_req(p_wbreq), .wb_val(p_wb), .mem_ready(mem_ready),
    .busy(busy), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_reg(req_reg), .req_hi(req_hi), .done(done),
    .wb_en(wb_en), .wb_value(wb_value)
  );

  p_write_dir_r12: assert property (@(posedge clk) disable iff (rst)
    (accept && !cmd_load && cmd_imm != '0) |=> req_write);
endmodule

// File: tb/sim_fpx_seq.sv
module sim_fpx_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [4:0]  rg;
    logic        hi;
  } word_t;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_load = 0, cmd_multi = 0, cmd_up = 0, cmd_wback = 0;
  logic cmd_double = 0, cmd_base_pc = 0, cmd_dbit = 0, big_endian = 0;
  logic [31:0] cmd_base = 0;
  logic [7:0]  cmd_imm = 0;
  logic [3:0]  cmd_vd = 0;
  logic busy, req_valid, req_write, req_hi, done, wb_en;
  logic [31:0] req_addr, wb_value;
  logic [4:0]  req_reg;
  logic mem_ready = 1;

  word_t exp_q[$];
  logic        exp_wbe;
  logic [31:0] exp_wbv;
  int total = 0, fails = 0, done_cnt = 0, cyc = 0;
  bit throttle = 0, finished = 0;
  logic stall_prev = 0;
  logic [31:0] prev_addr;
  logic [4:0]  prev_reg;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
    .cmd_multi(cmd_multi), .cmd_up(cmd_up), .cmd_wback(cmd_wback),
    .cmd_double(cmd_double), .cmd_base_pc(cmd_base_pc), .cmd_base(cmd_base),
    .cmd_imm(cmd_imm), .cmd_vd(cmd_vd), .cmd_dbit(cmd_dbit),
    .big_endian(big_endian), .busy(busy), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_reg(req_reg),
    .req_hi(req_hi), .mem_ready(mem_ready), .done(done), .wb_en(wb_en),
    .wb_value(wb_value)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // ready generator: changes just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    mem_ready = throttle ? (cyc % 3 != 1) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) begin
        chk(req_valid && req_addr == prev_addr && req_reg == prev_reg,
            "R9 stall hold addr", req_addr, prev_addr);
      end
      if (req_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected word", req_addr, 32'h0);
        end else begin
          word_t e;
          e = exp_q.pop_front();
          chk(req_write == e.wr, "R12 direction", {31'b0, req_write}, {31'b0, e.wr});
          chk(req_addr == e.addr, "R5/R6/R7/R8 address", req_addr, e.addr);
          chk(req_reg == e.rg, "R2 register index", {27'b0, req_reg}, {27'b0, e.rg});
          chk(req_hi == e.hi, "R3 half select", {31'b0, req_hi}, {31'b0, e.hi});
        end
      end
      stall_prev = req_valid && !mem_ready;
      prev_addr  = req_addr;
      prev_reg   = req_reg;
      if (done) begin
        chk(exp_q.size() == 0, "R4 words left at done", exp_q.size(), 0);
        chk(wb_en == exp_wbe, "R10 wb_en", {31'b0, wb_en}, {31'b0, exp_wbe});
        if (exp_wbe) chk(wb_value == exp_wbv, "R10 wb_value", wb_value, exp_wbv);
        done_cnt++;
      end
    end
  end

  task automatic run(input bit ld, input bit mu, input bit up, input bit wb,
                     input bit dbl, input bit pc, input bit be,
                     input logic [31:0] base, input logic [7:0] imm,
                     input logic [3:0] vd, input bit d, input bit poke);
    logic [31:0] off, b, st, wv;
    logic [4:0] first;
    int nw, d0;
    off = {22'b0, imm, 2'b00};
    if (!mu) begin
      b  = pc ? ((base + 32'd3) & ~32'd3) : base;
      st = up ? b + off : b - off;
      wv = b;
      nw = dbl ? 2 : 1;
      exp_wbe = 0;
    end else begin
      st = up ? base : base - off;
      wv = up ? base + off : base - off;
      nw = dbl ? 2 * (imm >> 1) : imm;
      exp_wbe = wb;
    end
    exp_wbv = wv;
    first = dbl ? {d, vd} : {vd, d};
    for (int j = 0; j < nw; j++) begin
      word_t e;
      e.wr   = ~ld;
      e.addr = st + 32'(4 * j);
      e.rg   = first + 5'(dbl ? j / 2 : j);
      e.hi   = dbl && (be ? (j % 2 == 0) : (j % 2 == 1));
      exp_q.push_back(e);
    end
    d0 = done_cnt;
    @(posedge clk); #2;
    cmd_load = ld; cmd_multi = mu; cmd_up = up; cmd_wback = wb; cmd_double = dbl;
    cmd_base_pc = pc; big_endian = be; cmd_base = base; cmd_imm = imm;
    cmd_vd = vd; cmd_dbit = d; cmd_valid = 1;
    @(posedge clk); #2;
    cmd_valid = 0;
    if (poke) begin
      chk(busy, "R11 busy during run", {31'b0, busy}, 32'h1);
      cmd_base = 32'hDEAD_0000; cmd_imm = 8'd1; cmd_up = ~up; big_endian = ~be;
      cmd_valid = 1;
      @(posedge clk); #2;
      cmd_valid = 0;
    end
    while (done_cnt == d0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R1 reset state", {busy, req_valid, done}, 3'b000);
    @(posedge clk); #2; rst = 0;
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R1 idle after reset", {busy, req_valid, done}, 3'b000);

    // R7: single load, add offset, single precision
    run(1, 0, 1, 1, 0, 0, 0, 32'h0000_1000, 8'd3, 4'd5, 1, 0);
    // R7: single store, subtract, PC rounding, double big-endian (R3)
    run(0, 0, 0, 0, 1, 1, 1, 32'h0000_2002, 8'd1, 4'd3, 1, 0);
    throttle = 1;
    // R6: upward multi, single precision, index wrap (R2)
    run(1, 1, 1, 1, 0, 0, 0, 32'h0000_3000, 8'd4, 4'd14, 1, 0);
    // R5: push form, double little-endian, with busy poke (R11)
    run(0, 1, 0, 1, 1, 0, 0, 32'h0000_4000, 8'd6, 4'd2, 0, 1);
    // R4: odd immediate with doubles, big-endian, upward
    run(1, 1, 1, 1, 1, 0, 1, 32'h0000_5000, 8'd5, 4'd7, 1, 0);
    // R10: zero-length transfer
    run(1, 1, 0, 1, 0, 0, 0, 32'h0000_6000, 8'd0, 4'd0, 0, 0);
    // R10: no write-back on multi
    run(0, 1, 1, 0, 0, 0, 0, 32'h0000_7000, 8'd3, 4'd1, 0, 1);
    throttle = 0;
    // R7: single double little-endian, PC base already aligned, subtract
    run(1, 0, 0, 1, 1, 1, 0, 32'h0000_8000, 8'd2, 4'd15, 1, 0);
    summary();
  end
endmodule